// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block keeps track of where incoming packets land in memory. Software places a circular ring of buffer descriptors in memory. Each descriptor holds a 32-bit buffer address and a 32-bit remaining word count, and each of those is stored as two 16-bit words. When a fetch is triggered, the block reads one descriptor through a 16-bit memory read port and loads the address and count. It then steps its ring read pointer to the next descriptor, wrapping to the ring start when the pointer lands exactly on the ring end. If the pointer then equals the write pointer that software maintains, the block raises an exhausted flag.

Packets are reported through a valid/ready stream that carries the stored length in bytes, including the 4-byte frame check sequence. For each accepted packet, the buffer address moves forward by that length and the word count drops by half of it. If the remaining count falls below an end-of-buffer threshold, the packet is marked as the last in its buffer and the next descriptor is fetched on its own. The packet data itself is not moved by this block.

Back-pressure rules:
- The memory request is held, with a stable address, until `rq_ready` is high. Only one request is outstanding at a time.
- Read data is taken on the first cycle in which `rs_valid` and `rs_ready` are both high.
- `pkt_ready` is low while the receiver is disabled, while the ring is exhausted, or while a fetch is pending or running.

Top module: `rx_ring_fetcher`

## Requirements
- R1: After reset the read pointer, buffer address, word count, exhausted flag, last-packet flag and fetch-busy output are all zero.
- R2: A fetch issues four reads at byte addresses {upper_addr, read_ptr + k*step} for k = 0..3. The step is 2 when `wide_mode` is 0 and 4 when it is 1. Words 0 and 1 load the low and high halves of the buffer address. Words 2 and 3 load the low and high halves of the word count.
- R3: At the end of a fetch the read pointer advances by 8 bytes when `wide_mode` is 0 and by 16 bytes when it is 1.
- R4: If the advanced read pointer equals `ring_end`, it is replaced by `ring_start`.
- R5: If the read pointer after a fetch (after any wrap) equals `ring_wr_ptr`, `exhausted` is set. It stays set until `exh_clr` is pulsed.
- R6: Pulsing `exh_clr` while `exhausted` is set clears the flag and starts a new fetch. Pulsing it while the flag is clear starts no fetch.
- R7: An accepted packet of N bytes adds N to the 32-bit buffer address and subtracts N/2 from the 32-bit word count. Carries and borrows propagate between the 16-bit halves.
- R8: `pkt_last` is updated on every accepted packet. It is 1 when the new word count is below `eob_count`. When it is set, a descriptor fetch follows without a command.
- R9: `pkt_ready` equals `rx_enable` AND NOT `exhausted` AND NOT `fetch_busy`. A packet offered while `pkt_ready` is low changes nothing.
- R10: `rp_load` writes `rp_load_value` into the read pointer with bit 0 forced to 0. The load is ignored while `fetch_busy` is high.
- R11: `fetch_busy` rises in the cycle after a `fetch_req` pulse and falls in the same cycle that the read pointer takes its advanced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upper_addr | input | 16 | Upper half of every descriptor read address |
| ring_start | input | 16 | Ring start address (lower half) |
| ring_end | input | 16 | Ring end address (lower half) |
| ring_wr_ptr | input | 16 | Write pointer maintained by software |
| eob_count | input | 16 | End-of-buffer word threshold |
| wide_mode | input | 1 | 1 selects 32-bit descriptor word spacing |
| rx_enable | input | 1 | Receiver enabled |
| fetch_req | input | 1 | Pulse that requests one descriptor fetch |
| exh_clr | input | 1 | Pulse that clears the exhausted flag |
| rp_load | input | 1 | Pulse that loads the read pointer |
| rp_load_value | input | 16 | Value for the read pointer |
| rq_valid | output | 1 | Memory read request valid |
| rq_ready | input | 1 | Memory read request accepted |
| rq_addr | output | 32 | Memory read byte address |
| rs_valid | input | 1 | Read data valid |
| rs_ready | output | 1 | Ready for read data |
| rs_data | input | 16 | Read data word |
| pkt_valid | input | 1 | Stored-packet report valid |
| pkt_ready | output | 1 | Stored-packet report accepted |
| pkt_bytes | input | 16 | Stored length in bytes, including the FCS |
| read_ptr | output | 16 | Ring read pointer |
| buf_addr | output | 32 | Current buffer address |
| word_count | output | 32 | Remaining buffer words |
| exhausted | output | 1 | Ring exhausted flag |
| pkt_last | output | 1 | Last accepted packet ended its buffer |
| fetch_busy | output | 1 | Fetch pending or in progress |

## Verification
The fetch path is driven from a table of ring layouts. The layouts cover:
- a plain step in the narrow spacing;
- an exact landing on the ring end, which shows that the wrap is taken;
- a landing on the write pointer, which shows that exhaustion is detected;
- the wide spacing, alone and combined with both a wrap and exhaustion.

The memory responder stalls a varying number of cycles. Matching the loaded words against memory therefore separates correct addressing from correct handshaking.

The accounting path is tried with three kinds of packet:
- a packet whose length carries the address across its 16-bit halves and borrows in the count;
- a packet that leaves the count just above the threshold;
- a packet that drops the count just below it, which must set the last flag and trigger a fetch on its own.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int DESC_WORDS = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_ADV} fetch_st_t;
endpackage

// File: rtl/rrf_fetch_fsm.sv
module rrf_fetch_fsm
  import rrf_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HW-1:0]     rp,
  input  logic [HW-1:0]     upper,
  input  logic              wide,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [2*HW-1:0]   rq_addr,
  input  logic              rs_valid,
  output logic              rs_ready,
  input  logic [HW-1:0]     rs_data,
  output logic              ld_en,
  output logic [$clog2(DESC_WORDS)-1:0] ld_idx,
  output logic [HW-1:0]     ld_data,
  output logic              adv,
  output logic              idle
);
  localparam int IW = $clog2(DESC_WORDS);

  fetch_st_t     st;
  logic [IW-1:0] idx;
  logic [HW-1:0] off;

  assign off      = wide ? (HW'(idx) << 2) : (HW'(idx) << 1);
  assign rq_addr  = {upper, rp + off};
  assign rq_valid = (st == ST_REQ);
  assign rs_ready = (st == ST_RSP);
  assign ld_en    = (st == ST_RSP) && rs_valid;
  assign ld_idx   = idx;
  assign ld_data  = rs_data;
  assign adv      = (st == ST_ADV);
  assign idle     = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_REQ;
          idx <= '0;
        end
        ST_REQ: if (rq_ready) st <= ST_RSP;
        ST_RSP: if (rs_valid) begin
          if (idx == IW'(DESC_WORDS - 1)) st <= ST_ADV;
          else begin
            idx <= idx + 1'b1;
            st  <= ST_REQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2/R11: a pending request keeps its address until accepted
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_addr));
endmodule

// File: rtl/rrf_ring_ptr.sv
module rrf_ring_ptr
  import rrf_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          wide,
  input  logic [HW-1:0] ring_start,
  input  logic [HW-1:0] ring_end,
  input  logic [HW-1:0] wr_ptr,
  input  logic          ld_valid,
  input  logic [HW-1:0] ld_value,
  input  logic          busy,
  input  logic          exh_clr,
  output logic [HW-1:0] rp,
  output logic          exhausted,
  output logic          refetch
);
  localparam int NARROW_STRIDE = DESC_WORDS * 2;

  logic [HW-1:0] stride;
  logic [HW-1:0] stepped;
  logic [HW-1:0] nxt;

  assign stride  = wide ? HW'(NARROW_STRIDE * 2) : HW'(NARROW_STRIDE);
  assign stepped = rp + stride;
  assign nxt     = (stepped == ring_end) ? ring_start : stepped;
  assign refetch = exh_clr && exhausted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp        <= '0;
      exhausted <= 1'b0;
    end else begin
      if (adv) rp <= nxt;
      else if (ld_valid && !busy) rp <= {ld_value[HW-1:1], 1'b0};
      if (adv && (nxt == wr_ptr)) exhausted <= 1'b1;
      else if (exh_clr) exhausted <= 1'b0;
    end
  end

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv && (ring_start != ring_end) |=> rp != $past(ring_end));
  assert_rp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !(ld_valid && !busy) |=> $stable(rp));
  assert_exh_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted && !exh_clr |=> exhausted);
endmodule

// File: rtl/rrf_rx_account.sv
module rrf_rx_account
  import rrf_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [$clog2(DESC_WORDS)-1:0] ld_idx,
  input  logic [HW-1:0]     ld_data,
  input  logic              acc,
  input  logic [HW-1:0]     bytes,
  input  logic [HW-1:0]     eob,
  output logic [2*HW-1:0]   buf_addr,
  output logic [2*HW-1:0]   word_count,
  output logic              last,
  output logic              refetch
);
  localparam int DW = 2 * HW;

  logic [DW-1:0] cnt_next;
  logic          last_next;

  assign cnt_next  = word_count - DW'(bytes >> 1);
  assign last_next = cnt_next < DW'(eob);
  assign refetch   = acc && last_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_addr   <= '0;
      word_count <= '0;
      last       <= 1'b0;
    end else if (acc) begin
      buf_addr   <= buf_addr + DW'(bytes);
      word_count <= cnt_next;
      last       <= last_next;
    end else if (ld_en) begin
      case (ld_idx)
        2'd0:    buf_addr[HW-1:0]    <= ld_data;
        2'd1:    buf_addr[DW-1:HW]   <= ld_data;
        2'd2:    word_count[HW-1:0]  <= ld_data;
        default: word_count[DW-1:HW] <= ld_data;
      endcase
    end
  end

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && !ld_en |=> $stable(word_count) && $stable(buf_addr));
endmodule

// File: rtl/rx_ring_fetcher.sv
module rx_ring_fetcher
  import rrf_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HW-1:0]   upper_addr,
  input  logic [HW-1:0]   ring_start,
  input  logic [HW-1:0]   ring_end,
  input  logic [HW-1:0]   ring_wr_ptr,
  input  logic [HW-1:0]   eob_count,
  input  logic            wide_mode,
  input  logic            rx_enable,
  input  logic            fetch_req,
  input  logic            exh_clr,
  input  logic            rp_load,
  input  logic [HW-1:0]   rp_load_value,
  output logic            rq_valid,
  input  logic            rq_ready,
  output logic [2*HW-1:0] rq_addr,
  input  logic            rs_valid,
  output logic            rs_ready,
  input  logic [HW-1:0]   rs_data,
  input  logic            pkt_valid,
  output logic            pkt_ready,
  input  logic [HW-1:0]   pkt_bytes,
  output logic [HW-1:0]   read_ptr,
  output logic [2*HW-1:0] buf_addr,
  output logic [2*HW-1:0] word_count,
  output logic            exhausted,
  output logic            pkt_last,
  output logic            fetch_busy
);
  localparam int IW = $clog2(DESC_WORDS);

  logic          pend;
  logic          idle;
  logic          start;
  logic          adv;
  logic          ld_en;
  logic [IW-1:0] ld_idx;
  logic [HW-1:0] ld_data;
  logic          exh_refetch;
  logic          last_refetch;
  logic          acc;

  assign start      = idle && pend;
  assign fetch_busy = pend || !idle;
  assign pkt_ready  = rx_enable && !exhausted && !fetch_busy;
  assign acc        = pkt_valid && pkt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (fetch_req || exh_refetch || last_refetch) pend <= 1'b1;
    else if (start) pend <= 1'b0;
  end

  rrf_fetch_fsm #(.HW(HW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .rp(read_ptr),
    .upper(upper_addr), .wide(wide_mode),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .adv(adv), .idle(idle)
  );

  rrf_ring_ptr #(.HW(HW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .wide(wide_mode),
    .ring_start(ring_start), .ring_end(ring_end), .wr_ptr(ring_wr_ptr),
    .ld_valid(rp_load), .ld_value(rp_load_value), .busy(fetch_busy),
    .exh_clr(exh_clr), .rp(read_ptr), .exhausted(exhausted),
    .refetch(exh_refetch)
  );

  rrf_rx_account #(.HW(HW)) u_acc (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .acc(acc), .bytes(pkt_bytes), .eob(eob_count),
    .buf_addr(buf_addr), .word_count(word_count), .last(pkt_last),
    .refetch(last_refetch)
  );

  assert_exh_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> !pkt_ready);
  assert_last_refetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_last) |-> fetch_busy);
  assert_clr_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exhausted) |-> fetch_busy);
endmodule

// File: tb/test_rx_ring_fetcher.sv
`timescale 1ns/1ps
module test_rx_ring_fetcher;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] upper_addr = 16'h00C4, ring_start = 0, ring_end = 0, ring_wr_ptr = 0;
  logic [15:0] eob_count = 16'd40, rp_load_value = 0, rs_data, pkt_bytes = 0;
  logic        wide_mode = 0, rx_enable = 1, fetch_req = 0, exh_clr = 0, rp_load = 0;
  logic        rq_valid, rq_ready, rs_valid, rs_ready, pkt_valid = 0, pkt_ready;
  logic [31:0] rq_addr, buf_addr, word_count;
  logic [15:0] read_ptr;
  logic        exhausted, pkt_last, fetch_busy;

  int tests = 0, fails = 0, addr_err = 0, nreq = 0;
  logic [15:0] mem [0:255];

  rx_ring_fetcher i_rx_ring_fetcher (.*);

  // fields: start rp, wide, ring start, ring end, write ptr, expected rp, expected exhausted
  localparam logic [15:0] ROWS [5][7] = '{
    '{16'h0020, 16'd0, 16'h0020, 16'h0040, 16'h0038, 16'h0028, 16'd0},
    '{16'h0038, 16'd0, 16'h0020, 16'h0040, 16'h0030, 16'h0020, 16'd0},
    '{16'h0030, 16'd0, 16'h0020, 16'h0040, 16'h0038, 16'h0038, 16'd1},
    '{16'h0020, 16'd1, 16'h0020, 16'h0060, 16'h0050, 16'h0030, 16'd0},
    '{16'h0050, 16'd1, 16'h0020, 16'h0060, 16'h0020, 16'h0020, 16'd1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mw(input logic [15:0] a);
    return mem[a[8:1]];
  endfunction

  // memory responder with varying stalls
  initial begin
    int ph = 0, stall = 0;
    logic [31:0] lat;
    rq_ready = 0; rs_valid = 0; rs_data = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin ph = 0; rq_ready = 0; rs_valid = 0; end
      else case (ph)
        0: if (rq_valid) begin
             if (stall > 0) stall--;
             else begin
               rq_ready = 1; lat = rq_addr; ph = 1;
               if (rq_addr[31:16] !== upper_addr) addr_err++;
             end
           end
        1: begin rq_ready = 0; rs_valid = 1; rs_data = mw(lat[15:0]); ph = 2; end
        default: begin rs_valid = 0; ph = 0; nreq++; stall = nreq % 3; end
      endcase
    end
  end

  task automatic do_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask
  task automatic pulse_fetch();
    @(negedge clk) fetch_req = 1; @(negedge clk) fetch_req = 0;
  endtask
  task automatic load_rp(input logic [15:0] v);
    @(negedge clk) begin rp_load = 1; rp_load_value = v; end
    @(negedge clk) rp_load = 0;
  endtask
  task automatic wait_idle();
    int n = 0;
    while (fetch_busy && n < 500) begin @(negedge clk); n++; end
    chk("R11", "fetch completes", {31'd0, fetch_busy}, 32'd0);
  endtask
  task automatic send_pkt(input logic [15:0] n);
    @(negedge clk) begin pkt_valid = 1; pkt_bytes = n; end
    @(negedge clk) pkt_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h3000 + 16'(i * 7);
    do_reset();
    // R1: reset state
    chk("R1", "read_ptr", {16'd0, read_ptr}, 0);
    chk("R1", "buf_addr", buf_addr, 0);
    chk("R1", "word_count", word_count, 0);
    chk("R1", "flags", {29'd0, exhausted, pkt_last, fetch_busy}, 0);
    chk("R9", "ready after reset", {31'd0, pkt_ready}, 1);

    // table of fetch scenarios (R2 R3 R4 R5)
    for (int r = 0; r < 5; r++) begin
      logic [15:0] rp0, s;
      int n0;
      do_reset();
      wide_mode = ROWS[r][1][0]; ring_start = ROWS[r][2];
      ring_end = ROWS[r][3]; ring_wr_ptr = ROWS[r][4];
      rp0 = ROWS[r][0]; s = wide_mode ? 16'd4 : 16'd2;
      load_rp(rp0);
      n0 = nreq;
      pulse_fetch();
      chk("R11", "busy after request", {31'd0, fetch_busy}, 1);
      wait_idle();
      chk("R2", "buffer address", buf_addr, {mw(rp0 + s), mw(rp0)});
      chk("R2", "word count", word_count, {mw(rp0 + 3*s), mw(rp0 + 2*s)});
      chk("R2", "four reads", nreq - n0, 4);
      chk("R3 R4", "read_ptr", {16'd0, read_ptr}, {16'd0, ROWS[r][5]});
      chk("R5", "exhausted", {31'd0, exhausted}, {31'd0, ROWS[r][6][0]});
    end
    chk("R2", "upper address half", addr_err, 0);

    // R5 R6 R9: exhaustion hold, clear and recovery
    do_reset();
    wide_mode = 0; ring_start = 16'h0020; ring_end = 16'h0040; ring_wr_ptr = 16'h0038;
    load_rp(16'h0030); pulse_fetch(); wait_idle();
    chk("R5", "exhausted set", {31'd0, exhausted}, 1);
    chk("R9", "ready while exhausted", {31'd0, pkt_ready}, 0);
    send_pkt(16'd64);
    chk("R9", "packet ignored while exhausted", buf_addr, {mw(16'h0032), mw(16'h0030)});
    repeat (3) @(negedge clk);
    chk("R5", "exhausted holds", {31'd0, exhausted}, 1);
    @(negedge clk) exh_clr = 1; @(negedge clk) exh_clr = 0;
    chk("R6", "cleared", {31'd0, exhausted}, 0);
    chk("R6", "refetch started", {31'd0, fetch_busy}, 1);
    wait_idle();
    chk("R6", "read_ptr after refetch", {16'd0, read_ptr}, 16'h0020);
    chk("R6", "buffer from refetch", buf_addr, {mw(16'h003A), mw(16'h0038)});
    @(negedge clk) exh_clr = 1; @(negedge clk) exh_clr = 0;
    chk("R6", "no fetch when not exhausted", {31'd0, fetch_busy}, 0);

    // R7 R8: accounting
    do_reset();
    wide_mode = 0; ring_start = 16'h0080; ring_end = 16'h00A0; ring_wr_ptr = 16'h0000;
    eob_count = 16'd40;
    mem[8'h40] = 16'hFFF0; mem[8'h41] = 16'h0001; mem[8'h42] = 16'h0005; mem[8'h43] = 16'h0001;
    mem[8'h44] = 16'h1000; mem[8'h45] = 16'h0002; mem[8'h46] = 16'd100;  mem[8'h47] = 16'h0000;
    mem[8'h48] = 16'h5000; mem[8'h49] = 16'h0003; mem[8'h4A] = 16'h0200; mem[8'h4B] = 16'h0000;
    load_rp(16'h0080); pulse_fetch(); wait_idle();
    send_pkt(16'h0020);
    chk("R7", "address carry", buf_addr, 32'h0002_0010);
    chk("R7", "count borrow", word_count, 32'h0000_FFF5);
    chk("R8", "not last", {31'd0, pkt_last}, 0);
    pulse_fetch(); wait_idle();
    send_pkt(16'd64);
    chk("R7", "address +64", buf_addr, 32'h0002_1040);
    chk("R7", "count -32", word_count, 32'd68);
    chk("R8", "68 not below 40", {30'd0, pkt_last, fetch_busy}, 0);
    send_pkt(16'd60);
    chk("R8", "38 below 40 sets last", {31'd0, pkt_last}, 1);
    chk("R8", "auto fetch started", {31'd0, fetch_busy}, 1);
    wait_idle();
    chk("R8", "next buffer loaded", buf_addr, 32'h0003_5000);
    chk("R8", "next count loaded", word_count, 32'h0000_0200);
    chk("R8", "read_ptr after auto fetch", {16'd0, read_ptr}, 16'h0098);

    // R9: receiver disabled
    rx_enable = 0;
    @(negedge clk);
    chk("R9", "ready when disabled", {31'd0, pkt_ready}, 0);
    send_pkt(16'd100);
    chk("R9", "disabled packet ignored", word_count, 32'h0000_0200);
    rx_enable = 1;

    // R10: pointer load
    load_rp(16'h0023);
    chk("R10", "bit 0 cleared", {16'd0, read_ptr}, 16'h0022);
    load_rp(16'h0080);
    pulse_fetch();
    load_rp(16'h0060);
    wait_idle();
    chk("R10", "load ignored while busy", {16'd0, read_ptr}, 16'h0088);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule